// File: doc/BRIEF.md
# Manchester Serial Word Encoder

This block sends one word at a time on a dual-rail Manchester II serial bus at one twelfth of the system clock rate. With a 12 MHz clock this is 1 Mb/s. Each word takes 20 bit times. It starts with a three-bit-time sync whose polarity marks a command/status word or a data word. Sixteen data bits follow, most significant bit first, and then an odd parity bit. While the bus is idle, both rails stay low.

The parallel word passes through two register ranks. The first rank follows the 16-bit input bus while its latch input is high, and keeps its value while that input is low. The second rank copies the first rank while its load input is low. It is frozen during the 16 bit times in which the send-data strobe is high, so the subsystem can prepare the next word while the current one is being shifted out.

A transmit cycle is armed when the active-low enable is seen low at the middle of a bit time (the falling edge of the shift clock). The cycle starts at the next bit boundary, and the sync type is sampled at that same boundary. If the enable is still low at the middle of the parity bit, the next word follows with no gap. An active-low output inhibit holds both rails low without touching the cycle. An active-low master abort clears the cycle at once.

Top module: `mwe_tx`

## Requirements
- R1: Bit times are CLK_DIV (12) clocks long, and `shift_tick` pulses for one clock at the start of every bit time, whether or not a word is being sent.
- R2: A word starts on a clock where `shift_tick` is high, at the first bit boundary after `enc_en_n` was sampled low at mid-bit. A word lasts exactly 20 bit times, and the rails return to low afterwards if the enable was released.
- R3: `sync_sel` is sampled at the start of the word. Low gives a command sync: `bus_pos` high for the first three half-bits, then `bus_neg` high for the next three. High gives the inverse pattern.
- R4: `send_data` is high for exactly 16 bit times. It rises at the start of bit time 3 of the word (the first data bit).
- R5: The second rank copies the first rank on every clock where `load_n` is low and `send_data` is low. It ignores its input while `send_data` is high or `load_n` is high.
- R6: The first rank follows `din` while `latch_en` is high and holds its value while `latch_en` is low.
- R7: While `out_inh_n` is low, both rails are low. Sequencing, `send_data` and the data sent in the remaining half-bits are unchanged.
- R8: If `enc_en_n` is still low at the middle of the parity bit, the next word's sync begins in the very next clock after the parity bit ends.
- R9: A clock with `mrst_n` low ends any word. From the next clock, both rails and `send_data` are low until a new enable.
- R10: During and after reset, with no enable, both rails and `send_data` are low.
- R11: In each data bit and the parity bit, a 1 is sent as `bus_pos` high then `bus_neg` high, and a 0 as the reverse. The parity bit makes the number of ones across the 16 data bits and the parity bit odd. The two rails are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz for 1 Mb/s) |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Parallel word input bus |
| latch_en | input | 1 | High: first rank follows `din`; low: holds |
| load_n | input | 1 | Low: second rank copies first rank when not sending |
| enc_en_n | input | 1 | Active-low transmit enable |
| sync_sel | input | 1 | High: data sync; low: command/status sync |
| out_inh_n | input | 1 | Active-low output inhibit |
| mrst_n | input | 1 | Active-low master abort of the transmit cycle |
| bus_pos | output | 1 | Positive bus rail |
| bus_neg | output | 1 | Negative bus rail |
| send_data | output | 1 | High while the 16 data bits shift out |
| shift_tick | output | 1 | One-clock pulse at every bit boundary |

## Verification
The parity bit time is the point where three functions meet in the same clock. The next word is armed from the enable, the second rank reloads because `send_data` has fallen, and the new sync type is captured at the boundary. The bench keeps the enable low through a word and changes `din` and `sync_sel` at the start of the parity half-bits. It then requires the second word to begin with zero idle clocks, to carry the new sync type and data, and to leave the first word's parity untouched. A second case changes `din` in the middle of `send_data` and requires the old word to go out whole.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    // Number of bit times taken by the sync pattern.
    localparam int unsigned SYNC_BITS = 3;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    // One Manchester half-bit: a 1 is positive first, then negative.
    function automatic rail_t enc_half(input logic val, input logic late);
        rail_t r;
        r.pos = val ^ late;
        r.neg = ~(val ^ late);
        return r;
    endfunction

    // Sync half: a command sync is positive first; a data sync is inverted.
    function automatic rail_t sync_half(input logic data_sync, input logic late_part);
        rail_t r;
        r.pos = ~(late_part ^ data_sync);
        r.neg = late_part ^ data_sync;
        return r;
    endfunction

endpackage

// File: rtl/mwe_prescale.sv
module mwe_prescale #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic sample_en,
    output logic bit_end,
    output logic late_half
);
    localparam int unsigned CW   = $clog2(DIV);
    localparam int unsigned HALF = DIV / 2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick      = (cnt_q == '0);
    assign sample_en = (cnt_q == CW'(HALF - 1));
    assign bit_end   = (cnt_q == CW'(DIV - 1));
    assign late_half = (cnt_q >= CW'(HALF));

    AST_TICK_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> tick); // R1
    AST_HALF_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> late_half); // R1

endmodule

// File: rtl/mwe_txreg.sv
module mwe_txreg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         latch_en,
    input  logic         load_n,
    input  logic         lock,
    output logic [W-1:0] word
);
    logic [W-1:0] rank1_q;
    logic [W-1:0] rank2_q;

    always_ff @(posedge clk) begin
        if (rst)
            rank1_q <= '0;
        else if (latch_en)
            rank1_q <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rank2_q <= '0;
        else if (!load_n && !lock)
            rank2_q <= rank1_q;
    end

    assign word = rank2_q;

    AST_RANK2_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(rank2_q)); // R5
    AST_RANK2_NOLOAD: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(rank2_q)); // R5
    AST_RANK1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch_en |=> $stable(rank1_q)); // R6

endmodule

// File: rtl/mwe_seq.sv
module mwe_seq
    import mwe_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned DIV = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mrst_n,
    input  logic         enc_en_n,
    input  logic         sync_sel,
    input  logic         tick,
    input  logic         sample_en,
    input  logic         bit_end,
    input  logic         late_half,
    input  logic [W-1:0] word,
    output rail_t        rail,
    output logic         send_data
);
    localparam int unsigned FRAME   = SYNC_BITS + W + 1;
    localparam int unsigned IW      = $clog2(FRAME);
    localparam int unsigned BW      = $clog2(W);
    localparam int unsigned DATA_LO = SYNC_BITS;
    localparam int unsigned DATA_HI = SYNC_BITS + W - 1;
    localparam int unsigned PAR_IDX = FRAME - 1;
    localparam int unsigned SEND_LEN = W * DIV;
    localparam int unsigned LW      = $clog2(SEND_LEN + 1);

    logic          active_q;
    logic          armed_q;
    logic [IW-1:0] idx_q;
    logic          dsync_q;
    logic          par_q;

    logic          last_bit;
    logic          in_data;
    logic [BW-1:0] dsel;
    logic          cur_bit;
    logic [IW:0]   hidx;

    assign last_bit  = (idx_q == IW'(PAR_IDX));
    assign in_data   = active_q && (idx_q >= IW'(DATA_LO)) && (idx_q <= IW'(DATA_HI));
    assign dsel      = BW'(IW'(DATA_HI) - idx_q);
    assign cur_bit   = word[dsel];
    assign hidx      = {idx_q, late_half};
    assign send_data = in_data;

    always_ff @(posedge clk) begin
        if (rst || !mrst_n) begin
            active_q <= 1'b0;
            armed_q  <= 1'b0;
            idx_q    <= '0;
            dsync_q  <= 1'b0;
            par_q    <= 1'b0;
        end else begin
            if (sample_en && (!active_q || last_bit) && !enc_en_n)
                armed_q <= 1'b1;
            if (bit_end) begin
                if (in_data)
                    par_q <= par_q ^ cur_bit;
                if (active_q && !last_bit) begin
                    idx_q <= idx_q + 1'b1;
                end else if (armed_q) begin
                    active_q <= 1'b1;
                    idx_q    <= '0;
                    dsync_q  <= sync_sel;
                    armed_q  <= 1'b0;
                    par_q    <= 1'b1;
                end else begin
                    active_q <= 1'b0;
                    idx_q    <= '0;
                end
            end
        end
    end

    always_comb begin
        rail = '0;
        if (active_q) begin
            if (idx_q < IW'(SYNC_BITS))
                rail = sync_half(dsync_q, hidx >= (IW + 1)'(SYNC_BITS));
            else if (last_bit)
                rail = enc_half(par_q, late_half);
            else
                rail = enc_half(cur_bit, late_half);
        end
    end

    // Checker-side length counter for the send strobe.
    logic [LW-1:0] sd_len_q;
    always_ff @(posedge clk) begin
        if (rst)
            sd_len_q <= '0;
        else if (send_data)
            sd_len_q <= sd_len_q + 1'b1;
        else
            sd_len_q <= '0;
    end

    AST_SEND_LENGTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(send_data) && $past(mrst_n)) |-> (sd_len_q == LW'(SEND_LEN))); // R4
    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> tick); // R2
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !mrst_n |=> (!active_q && !send_data)); // R9
    AST_SEND_RISE_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(send_data) |-> tick); // R4

endmodule

// File: rtl/mwe_tx.sv
module mwe_tx
    import mwe_pkg::*;
#(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned CLK_DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  logic              latch_en,
    input  logic              load_n,
    input  logic              enc_en_n,
    input  logic              sync_sel,
    input  logic              out_inh_n,
    input  logic              mrst_n,
    output logic              bus_pos,
    output logic              bus_neg,
    output logic              send_data,
    output logic              shift_tick
);
    logic              tick;
    logic              sample_en;
    logic              bit_end;
    logic              late_half;
    logic [WORD_W-1:0] word;
    rail_t             rail;
    logic              sd;

    mwe_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .sample_en (sample_en),
        .bit_end   (bit_end),
        .late_half (late_half)
    );

    mwe_txreg #(.W(WORD_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .latch_en (latch_en),
        .load_n   (load_n),
        .lock     (sd),
        .word     (word)
    );

    mwe_seq #(.W(WORD_W), .DIV(CLK_DIV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mrst_n    (mrst_n),
        .enc_en_n  (enc_en_n),
        .sync_sel  (sync_sel),
        .tick      (tick),
        .sample_en (sample_en),
        .bit_end   (bit_end),
        .late_half (late_half),
        .word      (word),
        .rail      (rail),
        .send_data (sd)
    );

    assign bus_pos    = rail.pos & out_inh_n;
    assign bus_neg    = rail.neg & out_inh_n;
    assign send_data  = sd;
    assign shift_tick = tick;

    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_pos && bus_neg)); // R11
    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_inh_n |-> (!bus_pos && !bus_neg)); // R7
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mrst_n |=> (!bus_pos && !bus_neg)); // R9

endmodule

// File: tb/sim_mwe_tx.sv
module sim_mwe_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din;
    logic        latch_en, load_n, enc_en_n, sync_sel, out_inh_n, mrst_n;
    logic        bus_pos, bus_neg, send_data, shift_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    mwe_tx u0 (
        .clk(clk), .rst(rst), .din(din), .latch_en(latch_en), .load_n(load_n),
        .enc_en_n(enc_en_n), .sync_sel(sync_sel), .out_inh_n(out_inh_n),
        .mrst_n(mrst_n), .bus_pos(bus_pos), .bus_neg(bus_neg),
        .send_data(send_data), .shift_tick(shift_tick)
    );

    always #10 clk = ~clk;

    // {sync_sel, data}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'hA5C3}, {1'b1, 16'h0000}, {1'b0, 16'hFFFF},
        {1'b1, 16'h8001}, {1'b1, 16'h1234}, {1'b0, 16'h7FFE}
    };

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_half(input logic ssel, input logic [15:0] d, input int k);
        logic p;
        int   j;
        if (k < 6) begin
            p = (k < 3) ^ ssel;
        end else if (k < 38) begin
            j = (k - 6) / 2;
            p = d[15 - j] ^ (k % 2 == 1);
        end else begin
            p = (~^d) ^ (k % 2 == 1);
        end
        return {p, ~p};
    endfunction

    task automatic cmpw(input string req, input logic ssel, input logic [15:0] d,
                        input int ia, input int ib, input logic [79:0] got);
        logic [79:0] e;
        for (int k = 0; k < 40; k++)
            e[2*k +: 2] = (k >= ia && k < ib) ? 2'b00 : exp_half(ssel, d, k);
        chk(req, got, e);
    endtask

    // Called at a negedge; returns at the negedge 240 clocks after the word starts.
    task automatic cap(input bit keep, input logic nssel, input logic [15:0] ndata,
                       input int ia, input int ib, input bit flip, input logic [15:0] cur,
                       output int lat, output logic [79:0] got, output int sdn,
                       output int sdf, output logic tick0);
        lat = 0; sdn = 0; sdf = -1; got = '0;
        while (!(bus_pos || bus_neg) && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        tick0 = shift_tick;
        for (int c = 0; c < 240; c++) begin
            if (c == 12 && !keep) enc_en_n = 1'b1;
            if (c == ia * 6) out_inh_n = 1'b0;
            if (c == ib * 6) out_inh_n = 1'b1;
            if (c == 60 && flip) din = ~cur;
            if (c == 228 && keep) begin din = ndata; sync_sel = nssel; end
            if (c % 6 == 3) got[2*(c/6) +: 2] = {bus_pos, bus_neg};
            if (send_data) begin
                sdn++;
                if (sdf < 0) sdf = c;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, lat2, sdn, sdf, n;
        logic [79:0] got, got2;
        logic t0;

        din = '0; latch_en = 1'b1; load_n = 1'b0; enc_en_n = 1'b1;
        sync_sel = 1'b0; out_inh_n = 1'b1; mrst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 rails in reset", {bus_pos, bus_neg}, 0);
        chk("R10 send_data in reset", send_data, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: ten ticks in 120 clocks, idle rails stay low (R10)
        n = 0;
        lat = 0;
        repeat (120) begin
            n += shift_tick;
            if (bus_pos || bus_neg || send_data) lat++;
            @(negedge clk);
        end
        chk("R1 tick count", n, 10);
        chk("R10 idle outputs", lat, 0);

        // Vector table: R2 R3 R4 R11
        foreach (VEC[i]) begin
            din = VEC[i][15:0];
            sync_sel = VEC[i][16];
            enc_en_n = 1'b0;
            cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b0, VEC[i][15:0], lat, got, sdn, sdf, t0);
            cmpw("R3 R11 vector word", VEC[i][16], VEC[i][15:0], -1, -1, got);
            chk("R4 send_data length", sdn, 192);
            chk("R4 send_data start", sdf, 36);
            chk("R2 start on tick", t0, 1);
            chk("R2 start latency bound", lat <= 20, 1);
            chk("R2 idle after 20 bits", {bus_pos, bus_neg}, 0);
            repeat (30) @(negedge clk);
        end

        // R8: chained words, second with data sync and new data
        din = 16'hC0DE; sync_sel = 1'b0; enc_en_n = 1'b0;
        cap(1'b1, 1'b1, 16'h3141, -1, -1, 1'b0, 16'hC0DE, lat, got, sdn, sdf, t0);
        cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b0, 16'h3141, lat2, got2, sdn, sdf, t0);
        cmpw("R8 first chained word", 1'b0, 16'hC0DE, -1, -1, got);
        cmpw("R8 second chained word", 1'b1, 16'h3141, -1, -1, got2);
        chk("R8 no gap between words", lat2, 0);
        repeat (30) @(negedge clk);

        // R7: inhibit during half-bits 8..19
        din = 16'h5A5A; sync_sel = 1'b1; enc_en_n = 1'b0;
        cap(1'b0, 1'b0, 16'h0, 8, 20, 1'b0, 16'h5A5A, lat, got, sdn, sdf, t0);
        cmpw("R7 inhibited word", 1'b1, 16'h5A5A, 8, 20, got);
        chk("R7 send_data undisturbed", sdn, 192);
        repeat (30) @(negedge clk);

        // R5: input change while sending is ignored
        din = 16'h9C31; sync_sel = 1'b0; enc_en_n = 1'b0;
        cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b1, 16'h9C31, lat, got, sdn, sdf, t0);
        cmpw("R5 frozen while sending", 1'b0, 16'h9C31, -1, -1, got);
        repeat (10) @(negedge clk);
        // R5: load_n high keeps second rank (holds ~9C31 loaded after send)
        load_n = 1'b1; din = 16'h0F0F;
        repeat (5) @(negedge clk);
        enc_en_n = 1'b0;
        cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b0, 16'h0F0F, lat, got, sdn, sdf, t0);
        cmpw("R5 load_n high holds", 1'b0, 16'h63CE, -1, -1, got);
        load_n = 1'b0;
        repeat (10) @(negedge clk);

        // R6: first rank hold
        din = 16'hBEEF; latch_en = 1'b1;
        repeat (2) @(negedge clk);
        latch_en = 1'b0; din = 16'h1111;
        repeat (3) @(negedge clk);
        sync_sel = 1'b1; enc_en_n = 1'b0;
        cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b0, 16'h1111, lat, got, sdn, sdf, t0);
        cmpw("R6 first rank held", 1'b1, 16'hBEEF, -1, -1, got);
        latch_en = 1'b1;
        repeat (10) @(negedge clk);

        // R9: abort mid-word
        din = 16'h7777; sync_sel = 1'b0; enc_en_n = 1'b0;
        n = 0;
        while (!(bus_pos || bus_neg) && n < 200) begin @(negedge clk); n++; end
        enc_en_n = 1'b1;
        repeat (50) @(negedge clk);
        mrst_n = 1'b0;
        @(negedge clk);
        mrst_n = 1'b1;
        chk("R9 rails after abort", {bus_pos, bus_neg}, 0);
        chk("R9 send_data after abort", send_data, 0);
        n = 0;
        repeat (300) begin
            if (bus_pos || bus_neg || send_data) n++;
            @(negedge clk);
        end
        chk("R9 quiet after abort", n, 0);
        din = 16'h2468; enc_en_n = 1'b0;
        cap(1'b0, 1'b0, 16'h0, -1, -1, 1'b0, 16'h2468, lat, got, sdn, sdf, t0);
        cmpw("R9 word after abort", 1'b0, 16'h2468, -1, -1, got);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule